// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is the arithmetic core of a vector unit's four-way byte dot-product operation. Each 32-bit lane of the operand vectors carries four packed 8-bit components. For every lane the block multiplies matching bytes of the two operands, adds the four products, and adds that sum to the lane's 32-bit accumulator. The second operand is either a second packed vector or one 32-bit scalar whose four bytes are broadcast to every lane. A two-bit select chooses how each operand's bytes are interpreted: as signed or unsigned.

A caller presents both operands, the old accumulator vector, the operand mode, the signedness select, an active-lane count and a per-lane mask, and raises `in_valid` for one cycle. Exactly one cycle later `out_valid` is high and `acc_out` holds the updated accumulator vector. Lanes that are masked off, or that lie at or beyond the active count, return their old accumulator value unchanged.

The output side is a two-state machine. `OUT_IDLE` means no result is held this cycle. `OUT_BUSY` means a result produced by the previous input is on `acc_out`. The transition `accept` (any state to `OUT_BUSY`) is taken on every cycle with `in_valid` high. The transition `drain` (any state to `OUT_IDLE`) is taken on every cycle with `in_valid` low. Reset enters `OUT_IDLE`.

Top module: `bdot_accum`

## Requirements
- R1: For each enabled lane, `acc_out` lane equals the `acc_in` lane plus the sum over k = 0..3 of operand A byte k times operand B byte k. Byte k of a lane is bits [8k+7:8k] of that lane, and lane i is bits [32i+31:32i]. Operand A is always `vs2`.
- R2: `sign_sel` = 0 treats both operands' bytes as signed.
- R3: `sign_sel` = 1 treats both operands' bytes as unsigned.
- R4: `sign_sel` = 2 treats `vs2` bytes as signed and operand B bytes as unsigned.
- R5: `sign_sel` = 3 with `mode_vx` = 1 treats `vs2` bytes as unsigned and the scalar's bytes as signed.
- R6: With `mode_vx` = 1, operand B of every lane is `scalar`, and `vs1` has no effect on the result.
- R7: `sign_sel` = 3 with `mode_vx` = 0 is not a supported combination. Every lane then returns its `acc_in` value.
- R8: A lane whose `lane_mask` bit is 0 returns its `acc_in` value.
- R9: A lane whose index is greater than or equal to `active_cnt` returns its `acc_in` value.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R11: While `in_valid` is low, `acc_out` holds its previous value.
- R12: During reset, `out_valid` is 0 and `acc_out` is all zeros.
- R13: The accumulation wraps modulo 2^32 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| mode_vx | input | 1 | 1 selects the broadcast scalar as operand B, 0 selects `vs1` |
| sign_sel | input | 2 | Signedness: 0 SxS, 1 UxU, 2 SxU, 3 UxS (scalar mode only) |
| vs2 | input | 32*NLANES | Operand A vector, four packed bytes per lane |
| vs1 | input | 32*NLANES | Operand B vector in vector mode |
| scalar | input | 32 | Operand B in scalar mode, broadcast to all lanes |
| acc_in | input | 32*NLANES | Old accumulator vector |
| active_cnt | input | $clog2(NLANES+1) | Number of active lanes counted from lane 0 |
| lane_mask | input | NLANES | Per-lane enable, 1 = update |
| out_valid | output | 1 | `acc_out` holds a fresh result |
| acc_out | output | 32*NLANES | Updated accumulator vector |

## Verification
The assertions take `in_valid` and every operand input to be 0 or 1 on each clock edge, with none left undriven. They also take the old accumulator to arrive on `acc_in` in the same cycle as its operands, so the hold properties can compare each lane against the `acc_in` value one cycle earlier. The bench drives every input at the falling edge from a single task, so each input is stable across the rising edge. It holds `in_valid` low for whole cycles between bursts, so the drain and hold properties are exercised next to back-to-back transfers.

// File: rtl/bdot_pkg.sv
package bdot_pkg;

    localparam int unsigned LANE_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BYTES_PER_LANE = LANE_W / BYTE_W;
    localparam int unsigned PROD_W = 2 * BYTE_W + 1;
    localparam int unsigned SUM_W = PROD_W + $clog2(BYTES_PER_LANE);

    typedef enum logic [1:0] {
        SGN_SS = 2'd0,
        SGN_UU = 2'd1,
        SGN_SU = 2'd2,
        SGN_US = 2'd3
    } sign_sel_e;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_BUSY = 1'b1
    } out_state_e;

endpackage

// File: rtl/bdot_sign_decode.sv
module bdot_sign_decode
    import bdot_pkg::*;
(
    input  logic       mode_vx,
    input  logic [1:0] sign_sel,
    output logic       a_signed,
    output logic       b_signed,
    output logic       unsupported
);

    sign_sel_e sel;

    always_comb begin
        sel         = sign_sel_e'(sign_sel);
        a_signed    = 1'b0;
        b_signed    = 1'b0;
        unsupported = 1'b0;
        unique case (sel)
            SGN_SS: begin
                a_signed = 1'b1;
                b_signed = 1'b1;
            end
            SGN_UU: begin
                a_signed = 1'b0;
                b_signed = 1'b0;
            end
            SGN_SU: begin
                a_signed = 1'b1;
                b_signed = 1'b0;
            end
            SGN_US: begin
                a_signed    = 1'b0;
                b_signed    = 1'b1;
                unsupported = !mode_vx;
            end
            default: begin
                unsupported = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bdot_lane.sv
module bdot_lane
    import bdot_pkg::*;
(
    input  logic [LANE_W-1:0] a_word,
    input  logic [LANE_W-1:0] b_word,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic [LANE_W-1:0] dot
);

    logic signed [PROD_W-1:0] prod [BYTES_PER_LANE];
    logic signed [SUM_W-1:0]  sum;

    for (genvar k = 0; k < BYTES_PER_LANE; k++) begin : g_byte
        logic signed [BYTE_W:0] a_ext;
        logic signed [BYTE_W:0] b_ext;
        always_comb begin
            a_ext   = {a_signed & a_word[BYTE_W*k+BYTE_W-1], a_word[BYTE_W*k +: BYTE_W]};
            b_ext   = {b_signed & b_word[BYTE_W*k+BYTE_W-1], b_word[BYTE_W*k +: BYTE_W]};
            prod[k] = a_ext * b_ext;
        end
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < BYTES_PER_LANE; k++) begin
            sum = sum + SUM_W'(prod[k]);
        end
        dot = LANE_W'(sum);
    end

endmodule

// File: rtl/bdot_accum.sv
module bdot_accum
    import bdot_pkg::*;
#(
    parameter int unsigned NLANES = 4,
    localparam int unsigned VEC_W = NLANES * LANE_W,
    localparam int unsigned CNT_W = $clog2(NLANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_vx,
    input  logic [1:0]       sign_sel,
    input  logic [VEC_W-1:0] vs2,
    input  logic [VEC_W-1:0] vs1,
    input  logic [31:0]      scalar,
    input  logic [VEC_W-1:0] acc_in,
    input  logic [CNT_W-1:0] active_cnt,
    input  logic [NLANES-1:0] lane_mask,
    output logic             out_valid,
    output logic [VEC_W-1:0] acc_out
);

    out_state_e state_q, state_d;
    logic a_signed, b_signed, unsupported;
    logic [VEC_W-1:0] next_acc;

    bdot_sign_decode u_decode (
        .mode_vx    (mode_vx),
        .sign_sel   (sign_sel),
        .a_signed   (a_signed),
        .b_signed   (b_signed),
        .unsupported(unsupported)
    );

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic [LANE_W-1:0] b_word;
        logic [LANE_W-1:0] dot;
        logic              enable;

        always_comb begin
            b_word = mode_vx ? scalar : vs1[LANE_W*i +: LANE_W];
            enable = lane_mask[i] && (active_cnt > CNT_W'(i)) && !unsupported;
            next_acc[LANE_W*i +: LANE_W] = enable
                ? acc_in[LANE_W*i +: LANE_W] + dot
                : acc_in[LANE_W*i +: LANE_W];
        end

        bdot_lane u_lane (
            .a_word  (vs2[LANE_W*i +: LANE_W]),
            .b_word  (b_word),
            .a_signed(a_signed),
            .b_signed(b_signed),
            .dot     (dot)
        );

        // R8: masked lane returns old accumulator
        assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_mask[i]) |=>
            (acc_out[LANE_W*i +: LANE_W] == $past(acc_in[LANE_W*i +: LANE_W])));

        // R9: lane at or past the active count returns old accumulator
        assert_tail_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (active_cnt <= CNT_W'(i))) |=>
            (acc_out[LANE_W*i +: LANE_W] == $past(acc_in[LANE_W*i +: LANE_W])));
    end

    always_comb begin
        unique case (state_q)
            OUT_IDLE: state_d = in_valid ? OUT_BUSY : OUT_IDLE;
            OUT_BUSY: state_d = in_valid ? OUT_BUSY : OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        acc_out <= '0;
        else if (in_valid) acc_out <= next_acc;
    end

    always_comb out_valid = (state_q == OUT_BUSY);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_out));

    assert_unsupported_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_vx && sign_sel == 2'd3) |=> (acc_out == $past(acc_in)));

endmodule

// File: tb/bdot_accum_tb.sv
module bdot_accum_tb;

    localparam int NL = 4;
    localparam int W  = NL * 32;
    localparam int CW = $clog2(NL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic mode_vx = 1'b0;
    logic [1:0] sign_sel = 2'd0;
    logic [W-1:0] vs2 = '0, vs1 = '0, acc_in = '0;
    logic [31:0] scalar = '0;
    logic [CW-1:0] active_cnt = '0;
    logic [NL-1:0] lane_mask = '0;
    logic out_valid;
    logic [W-1:0] acc_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];
    string tag_q[$];
    logic [W-1:0] last_exp = '0;

    always #2.5 clk = ~clk;

    bdot_accum #(.NLANES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_vx(mode_vx),
        .sign_sel(sign_sel), .vs2(vs2), .vs1(vs1), .scalar(scalar),
        .acc_in(acc_in), .active_cnt(active_cnt), .lane_mask(lane_mask),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic vx, input logic [1:0] sel,
        input logic [W-1:0] a_v, input logic [W-1:0] b_v, input logic [31:0] sc,
        input logic [W-1:0] acc, input logic [CW-1:0] cnt, input logic [NL-1:0] msk);
        logic [W-1:0] r;
        for (int l = 0; l < NL; l++) begin
            logic [31:0] a, b, s;
            a = a_v[32*l +: 32];
            b = vx ? sc : b_v[32*l +: 32];
            s = 0;
            for (int k = 0; k < 4; k++) begin
                int ai, bi;
                ai = (sel == 0 || sel == 2) ? int'($signed(a[8*k +: 8])) : int'(a[8*k +: 8]);
                bi = (sel == 0 || sel == 3) ? int'($signed(b[8*k +: 8])) : int'(b[8*k +: 8]);
                s = s + 32'(ai * bi);
            end
            if (!msk[l] || l >= int'(cnt) || (!vx && sel == 2'd3))
                r[32*l +: 32] = acc[32*l +: 32];
            else
                r[32*l +: 32] = acc[32*l +: 32] + s;
        end
        return r;
    endfunction

    task automatic send(input logic vx, input logic [1:0] sel, input logic [W-1:0] a_v,
        input logic [W-1:0] b_v, input logic [31:0] sc, input logic [W-1:0] acc,
        input logic [CW-1:0] cnt, input logic [NL-1:0] msk, input string tag);
        @(negedge clk);
        in_valid = 1'b1; mode_vx = vx; sign_sel = sel; vs2 = a_v; vs1 = b_v;
        scalar = sc; acc_in = acc; active_cnt = cnt; lane_mask = msk;
        exp_q.push_back(model(vx, sel, a_v, b_v, sc, acc, cnt, msk));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        vs2 = {NL{32'hA5A5_5A5A}};
        acc_in = {NL{32'h1234_5678}};
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", acc_out, '0);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(acc_out === e, t, acc_out, e);
            end
        end
    end

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [W-1:0] VA = {32'h80FF_7F01, 32'hFE02_8081, 32'h0102_0304, 32'h7F80_FF00};
    localparam logic [W-1:0] VB = {32'hFF80_017F, 32'h0305_FF80, 32'h8090_A0B0, 32'h0180_7FFF};
    localparam logic [W-1:0] AC = {32'h0000_1000, 32'hFFFF_FF00, 32'h7FFF_FFF0, 32'h1111_1111};

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R12 reset out_valid", W'(out_valid), '0);
        check(acc_out === '0, "R12 reset acc_out", acc_out, '0);
        @(negedge clk);
        rst_n = 1'b1;

        send(0, 2'd0, VA, VB, 32'h0, AC, 3'd4, 4'hF, "R1 R2 signed x signed vector");
        send(0, 2'd1, VA, VB, 32'h0, AC, 3'd4, 4'hF, "R3 unsigned x unsigned vector");
        send(0, 2'd2, VA, VB, 32'h0, AC, 3'd4, 4'hF, "R4 signed x unsigned vector");
        send(1, 2'd3, VA, VB, 32'h80FF_7F01, AC, 3'd4, 4'hF, "R5 unsigned x signed scalar");
        send(1, 2'd0, VA, ~VB, 32'hF0E1_0255, AC, 3'd4, 4'hF, "R6 scalar broadcast ignores vs1");
        send(1, 2'd0, VA, VB, 32'hF0E1_0255, AC, 3'd4, 4'hF, "R6 scalar broadcast ignores vs1");
        send(0, 2'd3, VA, VB, 32'h0, AC, 3'd4, 4'hF, "R7 unsupported vector UxS keeps acc");
        send(0, 2'd0, VA, VB, 32'h0, AC, 3'd4, 4'b1010, "R8 masked lanes keep acc");
        send(0, 2'd1, VA, VB, 32'h0, AC, 3'd2, 4'hF, "R9 lanes past active count keep acc");
        send(0, 2'd1, VA, VB, 32'h0, AC, 3'd0, 4'hF, "R9 zero active count");
        send(0, 2'd1, {NL{32'hFFFF_FFFF}}, {NL{32'hFFFF_FFFF}}, 32'h0, {NL{32'hFFFF_FFFF}},
             3'd4, 4'hF, "R13 wrap modulo 2^32");
        send(1, 2'd0, {NL{32'h8080_8080}}, VB, 32'h8080_8080, {NL{32'h7FFF_FFFF}},
             3'd4, 4'hF, "R13 signed extreme wrap");
        idle();
        @(negedge clk);
        check(out_valid === 1'b0, "R10 out_valid low after drain", W'(out_valid), '0);
        check(acc_out === last_exp, "R11 acc_out holds while idle", acc_out, last_exp);

        for (int n = 0; n < 24; n++) begin
            logic [W-1:0] a, b, c;
            for (int l = 0; l < NL; l++) begin
                a[32*l +: 32] = 32'(n * 32'h9E37_79B9 + l * 32'h0101_3377);
                b[32*l +: 32] = 32'(n * 32'h85EB_CA6B ^ l * 32'h00C3_A5F1);
                c[32*l +: 32] = 32'(n * 32'h27D4_EB2F + l);
            end
            send(n[0], 2'(n % 4), a, b, 32'(n * 32'h1B87_3593), c, 3'(n % 5), 4'(n * 7),
                 "R1 mixed back-to-back");
            if (n % 6 == 5) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all results delivered", W'(exp_q.size()), '0);
        check(out_valid === 1'b0, "R10 out_valid low at end", W'(out_valid), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule